// File: doc/BRIEF.md
# Zero-Address Stack Processor Core

This core runs programs whose arithmetic instructions carry no operand addresses. An internal operand stack supplies both arithmetic operands and takes back the single result. Only two instructions name a data-memory location. The load-to-stack instruction copies a memory word onto the top of the stack. The store-from-stack instruction removes the top word and writes it to memory. A halt instruction stops the program counter and raises a completion output.

The core fetches one 16-bit instruction word per clock from an instruction memory with combinational read. It executes that word in the same cycle, reading or writing a combinational-read data memory as the word requires. Two sticky error outputs report stack misuse. The underflow output flags a store or arithmetic operation that finds too few entries, and the overflow output flags a load onto a full stack. In both cases the stack is left as it was. A typical use is evaluating expressions: a compiler-style postfix sequence runs to a halt and leaves its result in data memory.

Top module: `stk_core`

## Requirements
- R1: A word with opcode 1 (load-to-stack) reads data memory at its address field and places the value on top of the stack.
- R2: A word with opcode 2 (store-from-stack) drives the top entry on the write-data port with the write enable high and the address field on the address port, then removes that entry.
- R3: Opcodes 3 (add) and 5 (multiply, low 16 bits of the product kept) replace the top two entries with one result.
- R4: Opcode 4 (subtract) replaces the top two entries with the top entry minus the entry below it.
- R5: A store with an empty stack, or an arithmetic opcode with fewer than two entries, sets the sticky unf_err output, writes no memory and leaves the stack unchanged.
- R6: A load onto a stack already holding 16 entries sets the sticky ovf_err output and discards the loaded value.
- R7: The instruction word holds the opcode in bits 15:12 and the address in bits 11:0. Opcode 0 and the unassigned codes do nothing. The address field has no effect for arithmetic opcodes.
- R8: Opcode 15 (halt) raises done from the next clock on. After that, imem_addr holds at the halt word and no later word executes.
- R9: While rst_n is low, imem_addr is 0, the stack is empty, and done, ovf_err and unf_err are low.
- R10: Until halt, imem_addr advances by one on every clock, so each instruction takes exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 12 | Program counter, instruction memory address |
| imem_rdata | input | 16 | Instruction word at imem_addr |
| dmem_addr | output | 12 | Data memory address (instruction address field) |
| dmem_rdata | input | 16 | Data memory word at dmem_addr |
| dmem_we | output | 1 | Data memory write enable |
| dmem_wdata | output | 16 | Data memory write value (top of stack) |
| done | output | 1 | Halt reached |
| ovf_err | output | 1 | Sticky stack overflow |
| unf_err | output | 1 | Sticky stack underflow |

## Verification
The hardest state to reach from the ports is a full stack that receives one more load. Reaching it needs sixteen successful loads in a row, followed by a program that reveals the dropped value without reading internal state. The stimulus loads seventeen distinct words and then stores sixteen times to consecutive addresses. The first stored word must be the sixteenth value loaded, and the last stored word must be the first value loaded. The underflow path is reached the same way. A store and an add run on a stack that is empty or holds one entry, and a following store shows that the single entry survived both.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int INSN_W = 16;
  localparam int OP_W   = 4;
  localparam int FLD_W  = INSN_W - OP_W;

  typedef enum logic [OP_W-1:0] {
    OP_NOP  = 4'h0,
    OP_PUSH = 4'h1,
    OP_POP  = 4'h2,
    OP_ADD  = 4'h3,
    OP_SUB  = 4'h4,
    OP_MUL  = 4'h5,
    OP_HALT = 4'hF
  } op_e;
endpackage

// File: rtl/stk_alu.sv
module stk_alu
  import stk_pkg::*;
#(
  parameter int DW = 16
) (
  input  op_e           op,
  input  logic [DW-1:0] top_val,
  input  logic [DW-1:0] sec_val,
  output logic [DW-1:0] res
);
  always_comb begin
    unique case (op)
      OP_ADD:  res = top_val + sec_val;
      OP_SUB:  res = top_val - sec_val;
      OP_MUL:  res = top_val * sec_val;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/stk_regfile.sv
module stk_regfile #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int SPW  = $clog2(DEPTH + 1),
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push_en,
  input  logic [DW-1:0]  push_data,
  input  logic           pop_en,
  input  logic           alu_en,
  input  logic [DW-1:0]  alu_res,
  output logic [DW-1:0]  top_val,
  output logic [DW-1:0]  sec_val,
  output logic [SPW-1:0] sp
);
  logic [DW-1:0]  slot_q [DEPTH];
  logic [SPW-1:0] sp_q, sp_d;
  logic           wr_en;
  logic [IW-1:0]  wr_idx;
  logic [DW-1:0]  wr_data;
  logic [IW-1:0]  top_idx, sec_idx;

  assign top_idx = IW'(sp_q - SPW'(1));
  assign sec_idx = IW'(sp_q - SPW'(2));
  assign top_val = slot_q[top_idx];
  assign sec_val = slot_q[sec_idx];
  assign sp      = sp_q;

  // A result overwrites the second entry; a push fills the free slot.
  assign wr_en   = push_en | alu_en;
  assign wr_idx  = push_en ? IW'(sp_q) : sec_idx;
  assign wr_data = push_en ? push_data : alu_res;

  always_comb begin
    sp_d = sp_q;
    if (push_en)                sp_d = sp_q + SPW'(1);
    else if (pop_en || alu_en)  sp_d = sp_q - SPW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= '0;
    else        sp_q <= sp_d;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == IW'(g))) slot_q[g] <= wr_data;
    end
  end
endmodule

// File: rtl/stk_fetch.sv
module stk_fetch #(
  parameter int PCW = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           halt_hit,
  output logic [PCW-1:0] pc,
  output logic           done
);
  logic [PCW-1:0] pc_q, pc_d;
  logic           done_q, done_d;
  logic           pc_en;

  assign pc_en  = !done_q && !halt_hit;
  assign pc_d   = pc_en ? pc_q + PCW'(1) : pc_q;
  assign done_d = done_q | halt_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      done_q <= 1'b0;
    end else begin
      pc_q   <= pc_d;
      done_q <= done_d;
    end
  end

  assign pc   = pc_q;
  assign done = done_q;
endmodule

// File: rtl/stk_core.sv
module stk_core
  import stk_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  parameter int PCW   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [PCW-1:0]    imem_addr,
  input  logic [INSN_W-1:0] imem_rdata,
  output logic [FLD_W-1:0]  dmem_addr,
  input  logic [DW-1:0]     dmem_rdata,
  output logic              dmem_we,
  output logic [DW-1:0]     dmem_wdata,
  output logic              done,
  output logic              ovf_err,
  output logic              unf_err
);
  localparam int SPW = $clog2(DEPTH + 1);

  op_e            op;
  logic           run, is_arith, has1, has2, full;
  logic           push_ok, pop_ok, alu_ok, halt_hit;
  logic           ovf_evt, unf_evt;
  logic           ovf_q, ovf_d, unf_q, unf_d;
  logic [DW-1:0]  top_val, sec_val, alu_res;
  logic [SPW-1:0] sp;

  assign op        = op_e'(imem_rdata[INSN_W-1:FLD_W]);
  assign dmem_addr = imem_rdata[FLD_W-1:0];
  assign run       = !done;
  assign is_arith  = (op == OP_ADD) || (op == OP_SUB) || (op == OP_MUL);
  assign has1      = (sp != '0);
  assign has2      = (sp > SPW'(1));
  assign full      = (sp == SPW'(DEPTH));

  assign push_ok  = run && (op == OP_PUSH) && !full;
  assign pop_ok   = run && (op == OP_POP)  && has1;
  assign alu_ok   = run && is_arith        && has2;
  assign halt_hit = run && (op == OP_HALT);
  assign ovf_evt  = run && (op == OP_PUSH) && full;
  assign unf_evt  = run && (((op == OP_POP) && !has1) || (is_arith && !has2));

  assign dmem_we    = pop_ok;
  assign dmem_wdata = top_val;

  stk_fetch #(.PCW(PCW)) u_fetch (
    .clk      (clk),
    .rst_n    (rst_n),
    .halt_hit (halt_hit),
    .pc       (imem_addr),
    .done     (done)
  );

  stk_regfile #(.DW(DW), .DEPTH(DEPTH)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_en   (push_ok),
    .push_data (dmem_rdata),
    .pop_en    (pop_ok),
    .alu_en    (alu_ok),
    .alu_res   (alu_res),
    .top_val   (top_val),
    .sec_val   (sec_val),
    .sp        (sp)
  );

  stk_alu #(.DW(DW)) u_alu (
    .op      (op),
    .top_val (top_val),
    .sec_val (sec_val),
    .res     (alu_res)
  );

  assign ovf_d = ovf_q | ovf_evt;
  assign unf_d = unf_q | unf_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  assign ovf_err = ovf_q;
  assign unf_err = unf_q;
endmodule

// File: rtl/stk_core_chk.sv
module stk_core_chk
  import stk_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PCW   = 12,
  localparam int SPW  = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PCW-1:0]    imem_addr,
  input logic [INSN_W-1:0] imem_rdata,
  input logic              dmem_we,
  input logic              done,
  input logic              ovf_err,
  input logic              unf_err,
  input logic [SPW-1:0]    sp
);
  logic [OP_W-1:0] opc;
  assign opc = imem_rdata[INSN_W-1:FLD_W];

  // R2
  write_only_on_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> (opc == OP_POP) && !done);

  // R5
  unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unf_err |=> unf_err);

  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);

  // R6
  full_push_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && opc == OP_PUSH && sp == SPW'(DEPTH)) |=> ovf_err && $stable(sp));

  // R6
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= SPW'(DEPTH));

  // R8
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done && $stable(imem_addr));

  // R8
  halt_raises_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && opc == OP_HALT) |=> done);

  // R10
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && opc != OP_HALT) |=> imem_addr == PCW'($past(imem_addr) + 1'b1));
endmodule

bind stk_core stk_core_chk #(.DEPTH(DEPTH), .PCW(PCW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .imem_addr  (imem_addr),
  .imem_rdata (imem_rdata),
  .dmem_we    (dmem_we),
  .done       (done),
  .ovf_err    (ovf_err),
  .unf_err    (unf_err),
  .sp         (sp)
);

// File: tb/sim_stk_core.sv
module sim_stk_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] imem_addr;
  logic [15:0] imem_rdata;
  logic [11:0] dmem_addr;
  logic [15:0] dmem_rdata;
  logic        dmem_we;
  logic [15:0] dmem_wdata;
  logic        done, ovf_err, unf_err;

  logic [15:0] imem [256];
  logic [15:0] dmem [256];
  int checks = 0;
  int errors = 0;
  int cyc;

  localparam logic [15:0] SENT = 16'hDEAD;

  always #5 clk = ~clk;

  assign imem_rdata = imem[imem_addr[7:0]];
  assign dmem_rdata = dmem[dmem_addr[7:0]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:0]] <= dmem_wdata;

  stk_core u0 (.*);

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] w(logic [3:0] op, logic [11:0] a);
    return {op, a};
  endfunction

  task automatic clear_all();
    rst_n = 1'b0;
    for (int i = 0; i < 256; i++) begin
      imem[i] = 16'hF000;
      dmem[i] = SENT;
    end
  endtask

  task automatic run_prog();
    @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    while (!done && cyc < 500) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  // {opcode, lower operand, top operand, expected result}
  localparam logic [51:0] VEC [5] = '{
    {4'h3, 16'h0003, 16'h0005, 16'h0008},
    {4'h4, 16'h0003, 16'h000A, 16'h0007},
    {4'h4, 16'h000A, 16'h0003, 16'hFFF9},
    {4'h5, 16'h1234, 16'h0010, 16'h2340},
    {4'h3, 16'hFFFF, 16'h0002, 16'h0001}
  };

  initial begin
    // R9 reset state
    clear_all();
    #1;
    chk("R9 pc", {4'h0, imem_addr}, 16'h0000);
    chk("R9 done/ovf/unf", {13'h0, done, ovf_err, unf_err}, 16'h0000);

    // R1 R3 R4 R7 R10: table walk, arithmetic words carry address 0xFFF
    for (int v = 0; v < 5; v++) begin
      clear_all();
      dmem[8'h10] = VEC[v][47:32];
      dmem[8'h11] = VEC[v][31:16];
      imem[0] = w(4'h1, 12'h010);
      imem[1] = w(4'h1, 12'h011);
      imem[2] = w(VEC[v][51:48], 12'hFFF);
      imem[3] = w(4'h2, 12'h012);
      imem[4] = w(4'hF, 12'h000);
      run_prog();
      chk("R3/R4 result", dmem[8'h12], VEC[v][15:0]);
      chk("R7 addr field ignored", dmem[8'hFF], SENT);
      chk("R10 cycles to done", 16'(cyc), 16'd5);
      chk("R5/R6 no flags", {14'h0, ovf_err, unf_err}, 16'h0000);
    end

    // R1 R2 R3 R4: postfix expression, B=2 C=3 D=4 E=5 F=6 A=7 -> A=22
    clear_all();
    dmem[8'h20] = 16'd7; dmem[8'h21] = 16'd2; dmem[8'h22] = 16'd3;
    dmem[8'h23] = 16'd4; dmem[8'h24] = 16'd5; dmem[8'h25] = 16'd6;
    imem[0]  = w(4'h1, 12'h024);
    imem[1]  = w(4'h1, 12'h022);
    imem[2]  = w(4'h1, 12'h023);
    imem[3]  = w(4'h5, 12'h000);
    imem[4]  = w(4'h1, 12'h021);
    imem[5]  = w(4'h3, 12'h000);
    imem[6]  = w(4'h4, 12'h000);
    imem[7]  = w(4'h1, 12'h025);
    imem[8]  = w(4'h3, 12'h000);
    imem[9]  = w(4'h1, 12'h020);
    imem[10] = w(4'h3, 12'h000);
    imem[11] = w(4'h2, 12'h020);
    run_prog();
    chk("R1 R2 R3 R4 expression", dmem[8'h20], 16'd22);

    // R7 no-op opcode 0 with address field does not touch memory
    clear_all();
    dmem[8'h10] = 16'h0042;
    imem[0] = w(4'h1, 12'h010);
    imem[1] = w(4'h0, 12'h030);
    imem[2] = w(4'h2, 12'h031);
    run_prog();
    chk("R7 nop no write", dmem[8'h30], SENT);
    chk("R2 R7 stack kept across nop", dmem[8'h31], 16'h0042);

    // R5 underflow: store on empty, add with one entry
    clear_all();
    dmem[8'h10] = 16'h0055;
    imem[0] = w(4'h2, 12'h030);
    imem[1] = w(4'h1, 12'h010);
    imem[2] = w(4'h3, 12'h000);
    imem[3] = w(4'h2, 12'h031);
    run_prog();
    chk("R5 no write on empty", dmem[8'h30], SENT);
    chk("R5 entry survives", dmem[8'h31], 16'h0055);
    chk("R5 unf set", {15'h0, unf_err}, 16'h0001);
    chk("R6 ovf clear", {15'h0, ovf_err}, 16'h0000);

    // R6 overflow: 17 loads, 16 stores
    clear_all();
    for (int i = 0; i < 17; i++) begin
      dmem[8'h50 + i] = 16'(100 + i);
      imem[i] = w(4'h1, 12'(8'h50 + i));
    end
    for (int j = 0; j < 16; j++) imem[17 + j] = w(4'h2, 12'(8'h70 + j));
    run_prog();
    chk("R6 ovf set", {15'h0, ovf_err}, 16'h0001);
    chk("R5 unf clear", {15'h0, unf_err}, 16'h0000);
    chk("R6 top is 16th value", dmem[8'h70], 16'd115);
    chk("R6 bottom is 1st value", dmem[8'h7F], 16'd100);
    chk("R6 slot beyond untouched", dmem[8'h80], SENT);

    // R8 halt stops the program counter and later words
    clear_all();
    dmem[8'h10] = 16'h0077;
    imem[0] = w(4'h1, 12'h010);
    imem[1] = w(4'hF, 12'h000);
    imem[2] = w(4'h2, 12'h020);
    run_prog();
    chk("R8 done", {15'h0, done}, 16'h0001);
    chk("R8 pc at halt", {4'h0, imem_addr}, 16'h0001);
    repeat (4) @(negedge clk);
    chk("R8 pc holds", {4'h0, imem_addr}, 16'h0001);
    chk("R8 no later store", dmem[8'h20], SENT);

    // R9 reset in mid-run clears everything
    rst_n = 1'b0;
    #1;
    chk("R9 async reset pc", {4'h0, imem_addr}, 16'h0000);
    chk("R9 async reset done", {15'h0, done}, 16'h0000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule